// File: doc/BRIEF.md
# Segment Privilege Access Checker

This block sits in front of address translation and decides, for each memory access, whether the current privilege level may touch the requested 32-bit virtual address. It looks at the top of the address to find the segment. It also checks the low address bits against the access width. From these it produces a grant, or an address-error flagged as either the load/fetch kind or the store kind. For a granted access it also tells downstream logic whether the address must go through translation or may be used as a physical address unchanged.

The address space is split into four 1 GB segments by the two top address bits. Segments 00 and 01 together form the 2 GB kernel region. Segment 10 holds user process space and segment 11 is a shared region; both may be used in either privilege mode. How much of the low space is closed to user mode depends on the virtual-memory enable: with translation on, the whole 2 GB kernel region is closed. With translation off, only the lowest 0.5 GB is closed, which is the part holding ROM and device registers. Kernel mode is never refused for privilege reasons.

The verdict is computed combinationally. A parameter selects whether it is presented directly or through one output register stage.

Top module: `segchk_top`

## Requirements
- R1: With the kernel bit at 1, a well-formed access is granted in every segment, whatever the VM-enable bit.
- R2: With VM-enable at 1 and the kernel bit at 0, any access whose address bit 31 is 0 (segments 00 and 01) is refused.
- R3: With VM-enable at 0 and the kernel bit at 0, an access with address bits 31:29 all zero is refused, while a well-formed access anywhere from 0x2000_0000 to 0x7FFF_FFFF is granted.
- R4: Well-formed accesses to segments 10 and 11 (address bit 31 at 1) are granted in user mode with either VM-enable value.
- R5: A refused or ill-formed access of kind load (code 00), fetch (code 10) or the reserved code 11 raises err_load and leaves err_store low.
- R6: A refused or ill-formed access of kind store (code 01) raises err_store and leaves err_load low.
- R7: An access is ill-formed when its size is word (code 10, or 11 which is treated as word) and address bits 1:0 are not 00, or when its size is halfword (code 01) and address bit 0 is 1. Byte accesses (code 00) are never misaligned. A fetch is always checked as a word, whatever the size code. The alignment check applies in kernel mode as well.
- R8: xlate is 1 exactly when the access is granted and VM-enable is 1. With VM-enable at 0, every granted address is passed through untranslated.
- R9: grant is 1 exactly when neither error output is 1.
- R10: With OUT_REG=1, the verdict for inputs present at a rising clock edge appears on the outputs after that edge, and reset drives all four outputs to 0. With OUT_REG=0, the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset of the output stage |
| vaddr | input | 32 | Virtual address of the access |
| acc_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 treated as load |
| acc_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 treated as word |
| kern_mode | input | 1 | 1 when the current privilege level is kernel |
| vm_on | input | 1 | 1 when virtual memory is enabled |
| grant | output | 1 | Access permitted |
| err_load | output | 1 | Address error, load/fetch kind |
| err_store | output | 1 | Address error, store kind |
| xlate | output | 1 | Granted access must be translated |

## Verification
The bench builds two copies with 32-bit addresses and a 3-bit low-region field: one with OUT_REG=1 and one with OUT_REG=0. Both copies see the same stimulus, so the registered copy's one-cycle delay and reset values are checked next to the combinational copy's same-cycle answer. Directed vectors cover the exact edges of the low region (0x1FFF_FFFC and 0x2000_0000) and the kernel/user boundary at 0x7FFF_FFFC and 0x8000_0000. They also cover every misalignment pattern under both access kinds. Seeded random vectors then mix all kinds, sizes, modes and VM settings across the full address range.

// File: rtl/segchk_pkg.sv
package segchk_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic grant;
        logic err_load;
        logic err_store;
        logic xlate;
    } verdict_t;

endpackage

// File: rtl/segchk_region.sv
module segchk_region #(
    parameter int ADDR_W = 32,
    parameter int LOW_W  = 3
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic              vm_on,
    output logic              in_guard
);
    localparam int TOP = ADDR_W - 1;

    logic whole_kernel;
    logic low_window;

    always_comb begin
        whole_kernel = ~vaddr[TOP];
        low_window   = (vaddr[TOP -: LOW_W] == '0);
        in_guard     = vm_on ? whole_kernel : low_window;
    end
endmodule

// File: rtl/segchk_align.sv
module segchk_align
    import segchk_pkg::*;
(
    input  logic [1:0] addr_lo,
    input  acc_kind_e  kind,
    input  acc_size_e  size,
    output logic       misaligned
);
    acc_size_e eff_size;

    always_comb begin
        eff_size = (kind == ACC_FETCH) ? SZ_WORD : size;
        unique case (eff_size)
            SZ_BYTE:          misaligned = 1'b0;
            SZ_HALF:          misaligned = addr_lo[0];
            SZ_WORD, SZ_WIDE: misaligned = |addr_lo;
            default:          misaligned = 1'b1;
        endcase
    end
endmodule

// File: rtl/segchk_decide.sv
module segchk_decide
    import segchk_pkg::*;
(
    input  logic      in_guard,
    input  logic      misaligned,
    input  logic      kern_mode,
    input  logic      vm_on,
    input  acc_kind_e kind,
    output verdict_t  verdict
);
    logic refused;
    logic faulty;

    always_comb begin
        refused = in_guard & ~kern_mode;
        faulty  = refused | misaligned;
        verdict.grant     = ~faulty;
        verdict.err_store = faulty & (kind == ACC_STORE);
        verdict.err_load  = faulty & (kind != ACC_STORE);
        verdict.xlate     = ~faulty & vm_on;
    end
endmodule

// File: rtl/segchk_top.sv
module segchk_top
    import segchk_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LOW_W   = 3,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [1:0]        acc_kind,
    input  logic [1:0]        acc_size,
    input  logic              kern_mode,
    input  logic              vm_on,
    output logic              grant,
    output logic              err_load,
    output logic              err_store,
    output logic              xlate
);
    localparam int TOP = ADDR_W - 1;

    acc_kind_e kind;
    acc_size_e size;
    logic      in_guard;
    logic      misaligned;
    verdict_t  c_v;
    verdict_t  o_v;

    assign kind = acc_kind_e'(acc_kind);
    assign size = acc_size_e'(acc_size);

    segchk_region #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_region (
        .vaddr    (vaddr),
        .vm_on    (vm_on),
        .in_guard (in_guard)
    );

    segchk_align u_align (
        .addr_lo    (vaddr[1:0]),
        .kind       (kind),
        .size       (size),
        .misaligned (misaligned)
    );

    segchk_decide u_decide (
        .in_guard   (in_guard),
        .misaligned (misaligned),
        .kern_mode  (kern_mode),
        .vm_on      (vm_on),
        .kind       (kind),
        .verdict    (c_v)
    );

    generate
        if (OUT_REG) begin : g_reg
            verdict_t q_v;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q_v <= '0;
                else        q_v <= c_v;
            end
            assign o_v = q_v;

            // R10: the registered verdict trails the combinational one by one edge
            a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (o_v == $past(c_v)));
        end else begin : g_comb
            assign o_v = c_v;
        end
    endgenerate

    assign grant     = o_v.grant;
    assign err_load  = o_v.err_load;
    assign err_store = o_v.err_store;
    assign xlate     = o_v.xlate;

    a_r9_grant_vs_err: assert property (@(posedge clk) disable iff (!rst_n)
        c_v.grant != (c_v.err_load | c_v.err_store));

    a_r5_single_err: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({c_v.err_load, c_v.err_store}));

    a_r6_store_kind: assert property (@(posedge clk) disable iff (!rst_n)
        c_v.err_store |-> (kind == ACC_STORE));

    a_r2_vm_user_low: assert property (@(posedge clk) disable iff (!rst_n)
        (vm_on && !kern_mode && !vaddr[TOP]) |-> !c_v.grant);

    a_r4_upper_open: assert property (@(posedge clk) disable iff (!rst_n)
        (vaddr[TOP] && size == SZ_BYTE && kind != ACC_FETCH) |-> c_v.grant);

    a_r1_kernel_open: assert property (@(posedge clk) disable iff (!rst_n)
        (kern_mode && !misaligned) |-> c_v.grant);

    a_r8_xlate_gate: assert property (@(posedge clk) disable iff (!rst_n)
        c_v.xlate |-> (vm_on && c_v.grant));

    a_r7_byte_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (size == SZ_BYTE && kind != ACC_FETCH) |-> !misaligned);
endmodule

// File: tb/segchk_top_tb.sv
module segchk_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] vaddr = '0;
    logic [1:0]  acc_kind = '0;
    logic [1:0]  acc_size = '0;
    logic        kern_mode = 1'b0;
    logic        vm_on = 1'b0;
    logic        r_grant, r_el, r_es, r_xl;
    logic        c_grant, c_el, c_es, c_xl;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    segchk_top #(.ADDR_W(32), .LOW_W(3), .OUT_REG(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .vaddr(vaddr), .acc_kind(acc_kind),
        .acc_size(acc_size), .kern_mode(kern_mode), .vm_on(vm_on),
        .grant(r_grant), .err_load(r_el), .err_store(r_es), .xlate(r_xl));

    segchk_top #(.ADDR_W(32), .LOW_W(3), .OUT_REG(1'b0)) u_dut_comb (
        .clk(clk), .rst_n(rst_n), .vaddr(vaddr), .acc_kind(acc_kind),
        .acc_size(acc_size), .kern_mode(kern_mode), .vm_on(vm_on),
        .grant(c_grant), .err_load(c_el), .err_store(c_es), .xlate(c_xl));

    function automatic logic is_mis(logic [31:0] a, logic [1:0] k, logic [1:0] s);
        logic [1:0] es;
        es = (k == 2'b10) ? 2'b10 : s;
        if (es == 2'b00) return 1'b0;
        if (es == 2'b01) return a[0];
        return a[1] | a[0];
    endfunction

    function automatic logic is_refused(logic [31:0] a, logic km, logic vm);
        if (km) return 1'b0;
        if (vm) return ~a[31];
        return (a[31:29] == 3'b000);
    endfunction

    // {grant, err_load, err_store, xlate}
    function automatic logic [3:0] expect_v(logic [31:0] a, logic [1:0] k,
                                            logic [1:0] s, logic km, logic vm);
        logic bad;
        bad = is_refused(a, km, vm) | is_mis(a, k, s);
        return {~bad, bad & (k != 2'b01), bad & (k == 2'b01), ~bad & vm};
    endfunction

    function automatic string tag_of(logic [31:0] a, logic [1:0] k,
                                     logic [1:0] s, logic km, logic vm);
        if (is_mis(a, k, s)) return "R7";
        if (is_refused(a, km, vm)) return (k == 2'b01) ? "R6" : (vm ? "R2" : "R3");
        if (km) return "R1";
        if (a[31]) return "R4";
        return "R8";
    endfunction

    task automatic check(string tag, string who, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s addr=%h kind=%b size=%b k=%b vm=%b got=%b exp=%b",
                     tag, who, vaddr, acc_kind, acc_size, kern_mode, vm_on, got, exp);
        end
    endtask

    task automatic apply(logic [31:0] a, logic [1:0] k, logic [1:0] s,
                         logic km, logic vm, string tag);
        logic [3:0] e;
        @(negedge clk);
        vaddr = a; acc_kind = k; acc_size = s; kern_mode = km; vm_on = vm;
        e = expect_v(a, k, s, km, vm);
        #1;
        check(tag, "comb R10", {c_grant, c_el, c_es, c_xl}, e);
        @(posedge clk);
        #1;
        check(tag, "reg R10", {r_grant, r_el, r_es, r_xl}, e);
        check("R9", "reg", {r_grant, 3'b000}, {~(r_el | r_es), 3'b000});
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0C0D));
        repeat (3) @(negedge clk);
        check("R10", "reset", {r_grant, r_el, r_es, r_xl}, 4'b0000);
        rst_n = 1'b1;

        // kernel everywhere
        apply(32'h0000_0000, 2'b00, 2'b10, 1'b1, 1'b1, "R1");
        apply(32'h1FC0_0100, 2'b10, 2'b10, 1'b1, 1'b0, "R1");
        apply(32'h7FFF_FFFC, 2'b01, 2'b10, 1'b1, 1'b1, "R1");
        // VM on, user, kernel region
        apply(32'h7FFF_FFFC, 2'b00, 2'b10, 1'b0, 1'b1, "R2");
        apply(32'h2000_0000, 2'b01, 2'b10, 1'b0, 1'b1, "R2");
        apply(32'h0000_0010, 2'b10, 2'b00, 1'b0, 1'b1, "R5");
        // VM off, low region edges
        apply(32'h1FFF_FFFC, 2'b00, 2'b10, 1'b0, 1'b0, "R3");
        apply(32'h1FFF_FFFC, 2'b01, 2'b10, 1'b0, 1'b0, "R6");
        apply(32'h2000_0000, 2'b00, 2'b10, 1'b0, 1'b0, "R3");
        apply(32'h7FFF_FFFC, 2'b01, 2'b10, 1'b0, 1'b0, "R3");
        // upper segments
        apply(32'h8000_0000, 2'b00, 2'b10, 1'b0, 1'b1, "R4");
        apply(32'hC000_0000, 2'b01, 2'b01, 1'b0, 1'b0, "R4");
        apply(32'hFFFF_FFFF, 2'b01, 2'b00, 1'b0, 1'b1, "R8");
        // misalignment
        apply(32'h8000_0002, 2'b00, 2'b10, 1'b0, 1'b1, "R7");
        apply(32'h8000_0002, 2'b00, 2'b01, 1'b0, 1'b1, "R7");
        apply(32'h8000_0001, 2'b01, 2'b01, 1'b1, 1'b0, "R7");
        apply(32'h8000_0003, 2'b01, 2'b00, 1'b1, 1'b0, "R7");
        apply(32'h8000_0002, 2'b10, 2'b00, 1'b1, 1'b1, "R7");
        apply(32'hC000_0001, 2'b01, 2'b11, 1'b0, 1'b0, "R7");
        apply(32'h8000_0004, 2'b11, 2'b10, 1'b0, 1'b1, "R5");
        apply(32'h0000_0001, 2'b11, 2'b00, 1'b0, 1'b0, "R5");

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            logic [1:0]  k, s;
            logic        km, vm;
            a  = $urandom;
            if (($urandom % 3) == 0) a[1:0] = 2'b00;
            k  = 2'($urandom);
            s  = 2'($urandom);
            km = 1'($urandom);
            vm = 1'($urandom);
            apply(a, k, s, km, vm, tag_of(a, k, s, km, vm));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule